// File: doc/BRIEF.md
# Load/Store Bus Master

This block is the only master on a single-transfer system bus with a handshake protocol. A sequencing controller gives it instruction fetches, data loads and data stores. The effective byte address is the sum of a base value and an offset, and each load or store carries an access size and a signedness flag. The block starts exactly one bus cycle for each accepted request.

For a store it places the write data on the byte lanes selected by the address and size, with matching byte selects. For a load or fetch it takes the addressed lanes of the returned word. A load is sign- or zero-extended to full width, and the result is held on `rdata`. A one-cycle `done` pulse tells the controller the transfer has finished. While a transfer is outstanding, `busy` is high and any new request is dropped.

Top module: `lsu_bus_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `wb_cyc`, `wb_stb`, `busy` and `done` are low and `rdata` is zero.
- R2: When `req_valid` is high and `busy` is low at a clock edge, `wb_cyc` and `wb_stb` are high from the next cycle. `wb_adr` is then `req_base + req_offset` (modulo 2^32) with its two low bits cleared.
- R3: `wb_cyc` and `wb_stb` are equal at all times. While `wb_ack` is low they stay high with `wb_adr`, `wb_sel`, `wb_we` and `wb_dat_o` unchanged. After the edge at which `wb_ack` is seen high, both drop and `done` is high for exactly that one cycle.
- R4: `busy` is high from the cycle after acceptance until the cycle of `done`. A request presented while `busy` is high is ignored and starts no bus cycle.
- R5: Op encoding: `req_op` 00 fetch, 01 load, 10 store, 11 load. Size encoding: `req_size` 00 byte, 01 halfword, 10 and 11 word. A store drives `wb_we` high. The byte select is 1 << addr[1:0] for a byte and 4'b0011 or 4'b1100 by addr[1] for a halfword. For a word it is 4'b1111. The store data is the low byte copied onto all four lanes, the low halfword copied onto both halves, or the whole word.
- R6: A byte load returns the lane picked by addr[1:0] (bits 8*addr[1:0] upward of `wb_dat_i`). It is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R7: A halfword load returns `wb_dat_i[31:16]` when addr[1] is 1 and `wb_dat_i[15:0]` otherwise. It is extended as in R6.
- R8: A fetch ignores size and signedness: it reads with `wb_we` low and `wb_sel` 4'b1111 and returns the full word. A word load behaves the same way.
- R9: A store leaves `rdata` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe from the controller |
| req_op | input | 2 | Fetch, load or store |
| req_size | input | 2 | Byte, halfword or word |
| req_unsigned | input | 1 | Zero-extend a load when set |
| req_base | input | 32 | Base address operand |
| req_offset | input | 32 | Offset added to the base |
| req_wdata | input | 32 | Store value, right-aligned |
| busy | output | 1 | A transfer is outstanding |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Extended load or fetch result |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | 32 | Word-aligned bus address |
| wb_sel | output | 4 | Byte lane selects |
| wb_dat_o | output | 32 | Write data on the lanes |
| wb_dat_i | input | 32 | Read data from the slave |
| wb_ack | input | 1 | Slave acknowledge |

## Verification
The bench walks a byte load across all four lanes and both halfwords, each signed and unsigned. The lane values straddle the sign bit, so a wrong shift or a wrong fill bit shows up as a wrong `rdata`. Stores use the same lane patterns: a select mask one lane off, or data that is not copied onto every lane, gives a bus value that differs from the expected one. A negative offset that crosses a word boundary exposes an address adder that truncates or drops the carry. A transfer with a long acknowledge delay has an intruding request presented during it. A master that accepted it would start an extra bus cycle after `done`, or change the address in mid-cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_FETCH = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_LOADX = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } sz_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [AW-1:0]         base,
  input  logic [AW-1:0]         offset,
  input  sz_e                   size,
  input  logic [DW-1:0]         wdata,
  output logic [AW-1:0]         bus_adr,
  output logic [$clog2(DW/8)-1:0] lane,
  output logic [DW/8-1:0]       sel,
  output logic [DW-1:0]         lanes_data
);
  localparam int SW = DW / 8;
  localparam int LB = $clog2(SW);

  // Byte-enable mask for an access of size s starting at lane lo.
  function automatic logic [SW-1:0] lane_mask(input sz_e s, input logic [LB-1:0] lo);
    logic [LB-1:0] hl;
    hl = lo;
    hl[0] = 1'b0;
    case (s)
      SZ_BYTE: lane_mask = SW'(1) << lo;
      SZ_HALF: lane_mask = SW'(3) << hl;
      default: lane_mask = {SW{1'b1}};
    endcase
  endfunction

  // Copy the right-aligned store value onto every lane it may occupy.
  function automatic logic [DW-1:0] replicate(input sz_e s, input logic [DW-1:0] w);
    logic [DW-1:0] r;
    r = w;
    case (s)
      SZ_BYTE: for (int i = 0; i < SW; i++) r[8*i +: 8] = w[7:0];
      SZ_HALF: for (int i = 0; i < SW/2; i++) r[16*i +: 16] = w[15:0];
      default: r = w;
    endcase
    return r;
  endfunction

  logic [AW-1:0] eff_addr;

  assign eff_addr   = base + offset;
  assign bus_adr    = {eff_addr[AW-1:LB], {LB{1'b0}}};
  assign lane       = eff_addr[LB-1:0];
  assign sel        = lane_mask(size, eff_addr[LB-1:0]);
  assign lanes_data = replicate(size, wdata);
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]           raw,
  input  logic [$clog2(DW/8)-1:0] lane,
  input  sz_e                     size,
  input  logic                    zext,
  output logic [DW-1:0]           value
);
  localparam int LB = $clog2(DW / 8);

  // Move the addressed lanes down to bit 0 and extend to full width.
  function automatic logic [DW-1:0] extract(input logic [DW-1:0] w, input logic [LB-1:0] lo,
                                            input sz_e s, input logic z);
    logic [LB-1:0] hl;
    logic [DW-1:0] sb;
    logic [DW-1:0] sh;
    hl = lo;
    hl[0] = 1'b0;
    sb = w >> {lo, 3'b000};
    sh = w >> {hl, 3'b000};
    case (s)
      SZ_BYTE: extract = z ? {{(DW-8){1'b0}}, sb[7:0]}  : {{(DW-8){sb[7]}}, sb[7:0]};
      SZ_HALF: extract = z ? {{(DW-16){1'b0}}, sh[15:0]} : {{(DW-16){sh[15]}}, sh[15:0]};
      default: extract = w;
    endcase
  endfunction

  assign value = extract(raw, lane, size, zext);
endmodule

// File: rtl/lsu_bus_fsm.sv
module lsu_bus_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic cyc,
  output logic stb,
  output logic done
);
  logic cyc_r, stb_r, done_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_r  <= 1'b0;
      stb_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= cyc_r && ack;
      if (cyc_r && ack) begin
        cyc_r <= 1'b0;
      end else if (start) begin
        cyc_r <= 1'b1;
      end
      if (stb_r && ack) begin
        stb_r <= 1'b0;
      end else if (start) begin
        stb_r <= 1'b1;
      end
    end
  end

  assign cyc  = cyc_r;
  assign stb  = stb_r;
  assign done = done_r;
endmodule

// File: rtl/lsu_bus_master.sv
module lsu_bus_master
  import lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [1:0]    req_size,
  input  logic          req_unsigned,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_offset,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_adr,
  output logic [DW/8-1:0] wb_sel,
  output logic [DW-1:0] wb_dat_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack
);
  localparam int SW = DW / 8;
  localparam int LB = $clog2(SW);

  op_e  op_in;
  sz_e  sz_eff;
  logic accept;
  logic xfer_end;

  logic [AW-1:0] adr_n;
  logic [LB-1:0] lane_n;
  logic [SW-1:0] sel_n;
  logic [DW-1:0] dat_n;

  logic [AW-1:0] adr_q;
  logic [LB-1:0] lane_q;
  logic [SW-1:0] sel_q;
  logic [DW-1:0] dat_q;
  logic          we_q;
  sz_e           sz_q;
  logic          zext_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] load_val;

  assign op_in    = op_e'(req_op);
  assign sz_eff   = (op_in == OP_FETCH) ? SZ_WORD : sz_e'(req_size);
  assign accept   = req_valid && !wb_cyc;
  assign xfer_end = wb_cyc && wb_ack;

  lsu_addr_gen #(.AW(AW), .DW(DW)) u_addr (
    .base       (req_base),
    .offset     (req_offset),
    .size       (sz_eff),
    .wdata      (req_wdata),
    .bus_adr    (adr_n),
    .lane       (lane_n),
    .sel        (sel_n),
    .lanes_data (dat_n)
  );

  lsu_bus_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .ack   (wb_ack),
    .cyc   (wb_cyc),
    .stb   (wb_stb),
    .done  (done)
  );

  lsu_load_align #(.DW(DW)) u_align (
    .raw   (wb_dat_i),
    .lane  (lane_q),
    .size  (sz_q),
    .zext  (zext_q),
    .value (load_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_q   <= '0;
      lane_q  <= '0;
      sel_q   <= '0;
      dat_q   <= '0;
      we_q    <= 1'b0;
      sz_q    <= SZ_WORD;
      zext_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        adr_q  <= adr_n;
        lane_q <= lane_n;
        sel_q  <= sel_n;
        dat_q  <= dat_n;
        we_q   <= (op_in == OP_STORE);
        sz_q   <= sz_eff;
        zext_q <= req_unsigned;
      end
      if (xfer_end && !we_q) begin
        rdata_q <= load_val;
      end
    end
  end

  assign busy     = wb_cyc;
  assign rdata    = rdata_q;
  assign wb_we    = we_q;
  assign wb_adr   = adr_q;
  assign wb_sel   = sel_q;
  assign wb_dat_o = dat_q;
endmodule

// File: rtl/lsu_bus_master_chk.sv
module lsu_bus_master_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            accept,
  input logic            xfer_end,
  input logic            busy,
  input logic            done,
  input logic            wb_cyc,
  input logic            wb_stb,
  input logic            wb_we,
  input logic [AW-1:0]   wb_adr,
  input logic [DW/8-1:0] wb_sel,
  input logic [DW-1:0]   wb_dat_o,
  input logic            wb_ack
);
  localparam int SW = DW / 8;

  // R3
  stb_match_chk: assert property (@(posedge clk) disable iff (!rst_n) wb_stb == wb_cyc);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && !wb_ack |=> wb_cyc && $stable(wb_adr) && $stable(wb_sel)
                          && $stable(wb_we) && $stable(wb_dat_o));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !wb_cyc && done);

  // R3
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(xfer_end));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wb_cyc && wb_stb && busy);

  // R4
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid && !wb_ack |=> wb_cyc && $stable(wb_adr));

  // R5
  sel_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc |-> ($countones(wb_sel) == 1 || $countones(wb_sel) == 2 || $countones(wb_sel) == SW));
endmodule

bind lsu_bus_master lsu_bus_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .accept    (accept),
  .xfer_end  (xfer_end),
  .busy      (busy),
  .done      (done),
  .wb_cyc    (wb_cyc),
  .wb_stb    (wb_stb),
  .wb_we     (wb_we),
  .wb_adr    (wb_adr),
  .wb_sel    (wb_sel),
  .wb_dat_o  (wb_dat_o),
  .wb_ack    (wb_ack)
);

// File: tb/lsu_bus_master_tb.sv
module lsu_bus_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [1:0]  req_size;
  logic        req_unsigned;
  logic [31:0] req_base;
  logic [31:0] req_offset;
  logic [31:0] req_wdata;
  logic        busy, done;
  logic [31:0] rdata;
  logic        wb_cyc, wb_stb, wb_we;
  logic [31:0] wb_adr;
  logic [3:0]  wb_sel;
  logic [31:0] wb_dat_o;
  logic [31:0] wb_dat_i;
  logic        wb_ack;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lsu_bus_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_ack(wb_ack)
  );

  typedef struct packed {
    logic [31:0] adr;
    logic [3:0]  sel;
    logic        we;
    logic [31:0] dat;
    logic [31:0] rd;
    logic [1:0]  kind; // 0 word/fetch, 1 byte load, 2 half load, 3 store
  } exp_t;

  exp_t        q[$];
  logic [31:0] last_rd = 32'h0;
  int          ack_lat = 0;
  logic [31:0] slave_word = 32'h0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_sel(input logic [1:0] op, input logic [1:0] sz, input logic [1:0] lo);
    if (op == 2'b00 || sz[1]) return 4'b1111;
    if (sz == 2'b01) return lo[1] ? 4'b1100 : 4'b0011;
    case (lo)
      2'd0: return 4'b0001;
      2'd1: return 4'b0010;
      2'd2: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic logic [31:0] exp_lanes(input logic [1:0] sz, input logic [31:0] w);
    if (sz == 2'b00) return {w[7:0], w[7:0], w[7:0], w[7:0]};
    if (sz == 2'b01) return {w[15:0], w[15:0]};
    return w;
  endfunction

  function automatic logic [31:0] exp_load(input logic [1:0] op, input logic [1:0] sz, input logic u,
                                           input logic [1:0] lo, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    if (op == 2'b00 || sz[1]) return w;
    if (sz == 2'b01) begin
      h = lo[1] ? w[31:16] : w[15:0];
      return u ? {16'h0000, h} : {{16{h[15]}}, h};
    end
    case (lo)
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    return u ? {24'h0, b} : {{24{b[7]}}, b};
  endfunction

  // Slave model: acknowledges after ack_lat wait cycles, ack lasts one cycle.
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    wb_ack = 1'b0;
    wb_dat_i = 32'h0;
    forever begin
      @(negedge clk);
      if (wb_ack) begin
        wb_ack = 1'b0;
      end else if (wb_cyc) begin
        if (wait_cnt >= ack_lat) begin
          wb_ack = 1'b1;
          wb_dat_i = slave_word;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // Monitor: compares bus fields at cycle start and the result at done.
  initial begin
    logic prev_cyc;
    logic [31:0] cap_adr;
    logic [3:0]  cap_sel;
    exp_t cur;
    prev_cyc = 1'b0;
    cap_adr = 32'h0;
    cap_sel = 4'h0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (wb_cyc && !prev_cyc) begin
          if (q.size() == 0) begin
            check("R4 unexpected bus cycle", 32'd1, 32'd0);
          end else begin
            cur = q[0];
            check("R2 bus address", wb_adr, cur.adr);
            check("R5 byte select", {28'h0, wb_sel}, {28'h0, cur.sel});
            check("R5 write enable", {31'h0, wb_we}, {31'h0, cur.we});
            if (cur.we) check("R5 store lane data", wb_dat_o, cur.dat);
            check("R4 busy during cycle", {31'h0, busy}, 32'd1);
            check("R3 strobe with cycle", {31'h0, wb_stb}, 32'd1);
          end
          cap_adr = wb_adr;
          cap_sel = wb_sel;
        end else if (wb_cyc) begin
          check("R3 address held", wb_adr, cap_adr);
          check("R3 select held", {28'h0, wb_sel}, {28'h0, cap_sel});
        end
        if (done) begin
          if (q.size() == 0) begin
            check("R3 stray done", 32'd1, 32'd0);
          end else begin
            cur = q.pop_front();
            case (cur.kind)
              2'd0: check("R8 word result", rdata, cur.rd);
              2'd1: check("R6 byte result", rdata, cur.rd);
              2'd2: check("R7 half result", rdata, cur.rd);
              default: check("R9 rdata kept after store", rdata, cur.rd);
            endcase
            check("R3 bus released at done", {31'h0, wb_cyc}, 32'd0);
            check("R4 busy low at done", {31'h0, busy}, 32'd0);
          end
        end
        prev_cyc = wb_cyc;
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [1:0] sz, input logic u,
                       input logic [31:0] base, input logic [31:0] off, input logic [31:0] wd,
                       input logic [31:0] word, input int lat, input bit intrude);
    logic [31:0] a;
    exp_t e;
    a = base + off;
    e.adr = {a[31:2], 2'b00};
    e.sel = exp_sel(op, sz, a[1:0]);
    e.we  = (op == 2'b10);
    e.dat = exp_lanes(sz, wd);
    if (e.we) begin
      e.rd = last_rd;
      e.kind = 2'd3;
    end else begin
      e.rd = exp_load(op, sz, u, a[1:0], word);
      e.kind = (op == 2'b00 || sz[1]) ? 2'd0 : (sz == 2'b00 ? 2'd1 : 2'd2);
      last_rd = e.rd;
    end
    q.push_back(e);
    slave_word = word;
    ack_lat = lat;
    @(negedge clk);
    req_op = op; req_size = sz; req_unsigned = u;
    req_base = base; req_offset = off; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      req_op = 2'b10; req_base = 32'h5555_0000; req_offset = 32'h0;
      req_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    if (intrude) begin
      @(negedge clk);
      check("R4 ignored request started no cycle", {31'h0, wb_cyc}, 32'd0);
      @(negedge clk);
      check("R4 ignored request started no cycle", {31'h0, wb_cyc}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b1;
    req_op = 2'b01; req_size = 2'b10; req_unsigned = 1'b0;
    req_base = 32'h0; req_offset = 32'h0; req_wdata = 32'h0;
    repeat (4) @(negedge clk);
    // R1: reset state while a request is held
    check("R1 cyc in reset", {31'h0, wb_cyc}, 32'd0);
    check("R1 busy in reset", {31'h0, busy}, 32'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cyc after reset", {31'h0, wb_cyc}, 32'd0);
    check("R1 stb after reset", {31'h0, wb_stb}, 32'd0);
    check("R1 done after reset", {31'h0, done}, 32'd0);
    check("R1 rdata after reset", rdata, 32'h0);

    // R8: fetch ignores size and signedness
    issue(2'b00, 2'b00, 1'b1, 32'h0000_0100, 32'h4, 32'h0, 32'hDEAD_BEEF, 0, 1'b0);
    issue(2'b01, 2'b10, 1'b0, 32'h0000_2000, 32'h8, 32'h0, 32'h8765_4321, 2, 1'b0);
    issue(2'b01, 2'b11, 1'b1, 32'h0000_2000, 32'hC, 32'h0, 32'hF000_000F, 1, 1'b0);

    // R6: every byte lane, signed and unsigned
    for (int i = 0; i < 4; i++) begin
      issue(2'b01, 2'b00, 1'b0, 32'h0000_3000, i, 32'h0, 32'h80F1_7F01, i % 2, 1'b0);
      issue(2'b11, 2'b00, 1'b1, 32'h0000_3000, i, 32'h0, 32'h80F1_7F01, 0, 1'b0);
    end

    // R7: both halves, signed and unsigned
    issue(2'b01, 2'b01, 1'b0, 32'h0000_4000, 32'h0, 32'h0, 32'hC3A5_4B12, 0, 1'b0);
    issue(2'b01, 2'b01, 1'b0, 32'h0000_4000, 32'h2, 32'h0, 32'hC3A5_4B12, 0, 1'b0);
    issue(2'b01, 2'b01, 1'b1, 32'h0000_4000, 32'h2, 32'h0, 32'hC3A5_4B12, 3, 1'b0);
    issue(2'b01, 2'b01, 1'b0, 32'h0000_4000, 32'h0, 32'h0, 32'h0000_8001, 0, 1'b0);

    // R2: negative offset crossing a word boundary
    issue(2'b01, 2'b00, 1'b0, 32'h0000_1000, 32'hFFFF_FFFD, 32'h0, 32'h0000_9900, 0, 1'b0);

    // R5, R9: stores at every size and lane
    for (int i = 0; i < 4; i++)
      issue(2'b10, 2'b00, 1'b0, 32'h0000_5000, i, 32'h1234_56A7, 32'h0, i, 1'b0);
    issue(2'b10, 2'b01, 1'b0, 32'h0000_5000, 32'h0, 32'hAAAA_BEEF, 32'h0, 0, 1'b0);
    issue(2'b10, 2'b01, 1'b1, 32'h0000_5000, 32'h2, 32'hAAAA_BEEF, 32'h0, 1, 1'b0);
    issue(2'b10, 2'b10, 1'b0, 32'h0000_5000, 32'h4, 32'hCAFE_F00D, 32'h0, 0, 1'b0);

    // R4: request while busy is ignored
    issue(2'b01, 2'b10, 1'b0, 32'h0000_6000, 32'h0, 32'h0, 32'h1357_9BDF, 5, 1'b1);

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", q.size(), 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule